// File: doc/BRIEF.md
# Iterative Carry-Save Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns the full 2*WIDTH-bit product. The work is split into three timed phases. A single cycle forms one partial-product row per multiplier bit. Repeated compression rounds then squeeze the row array held in registers. The last two surviving rows go through one carry-propagate addition.

Each compression round sorts the live rows into triples. Every triple feeds one full adder per column. The sum bit stays in its column and is written to an even slot of the next array (0, 2, 4, ...). The carry moves one column to the left and is written to the odd slot just after it. The rows left over after the triples are handled differently. A lone row passes through an adder with zero, which leaves it unchanged. A pair of rows is copied unchanged. Every slot past the new live count is cleared.

From R live rows a round leaves 2*floor(R/3) + (R mod 3) rows. The number of rounds therefore depends only on WIDTH. It is fixed at elaboration time, and each round is paced to three cycles by a phase counter. A start pulse is accepted only while the block is idle, and the operands are latched on that same edge.

Top module: `csa_mult_iter`

## Requirements
- R1: While reset is held and immediately after it, `done_o` is 0 and `prod_o` is 0.
- R2: For any operands, the value in `prod_o` when `done_o` is high equals a_i*b_i as a 2*WIDTH-bit unsigned value. For WIDTH=8, 255*255 gives 65025.
- R3: `done_o` rises exactly 2+3*r clock edges after the edge that accepts start. Here r is the number of rounds needed to reduce WIDTH rows to at most two, using the rule 2*floor(R/3)+(R mod 3). For WIDTH=8 the schedule is 8,6,4,3,2, so r=4 and `done_o` rises 14 edges after the accepting edge.
- R4: `done_o` is high for exactly one cycle. `prod_o` keeps its value until the next result is written.
- R5: A start pulse that arrives while a multiplication is in progress is ignored. No extra result is produced, and the current result is unchanged.
- R6: The operands are captured on the edge that accepts start. Later changes on a_i or b_i have no effect on the result.
- R7: During every reduction round, the row array, summed with wrap-around to 2*WIDTH bits, equals the product of the captured operands.
- R8: A start presented in the same cycle that `done_o` is high is accepted, because the block is already idle then. The new result follows with the R3 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronized upstream |
| start_i | input | 1 | Request a multiplication; sampled only when idle |
| a_i | input | WIDTH | Multiplicand |
| b_i | input | WIDTH | Multiplier |
| done_o | output | 1 | One-cycle pulse marking a new product |
| prod_o | output | 2*WIDTH | Product, held between results |

## Verification
With the default WIDTH of 8, `done_o` is due exactly 14 rising edges after the edge that samples an accepted start. The product must be valid in that same cycle, and `done_o` must be low again on the edge after. The bench drives inputs and samples outputs on falling edges, and counts the falling edges between the accepting edge and the first sight of `done_o`. That count must be 14 in the normal case. When a stray start is injected four edges after launch, the count must be 10. After a stray start, the bench keeps watching for longer than a full latency and expects no second pulse.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GEN  = 2'd1,
    ST_RED  = 2'd2,
    ST_ADD  = 2'd3
  } mult_state_e;

  // live rows left after one compression round
  function automatic int rows_next(input int live);
    if (live <= 2) return live;
    return 2 * (live / 3) + (live % 3);
  endfunction

  // live rows at the start of round k
  function automatic int rows_at_round(input int width, input int k);
    int live;
    live = width;
    for (int i = 0; i < k; i++) live = rows_next(live);
    return live;
  endfunction

  // rounds needed to reach two rows or fewer
  function automatic int round_total(input int width);
    int live;
    int r;
    live = width;
    r = 0;
    while (live > 2) begin
      live = rows_next(live);
      r++;
    end
    return r;
  endfunction

endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0]         mcand,
  input  logic [WIDTH-1:0]         mplier,
  output logic [WIDTH-1:0][PW-1:0] rows
);

  // row i is the multiplicand gated by multiplier bit i, aligned to column i
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_row
    assign rows[gi] = {{WIDTH{1'b0}}, mcand & {WIDTH{mplier[gi]}}} << gi;
  end

endmodule

// File: rtl/csa_round.sv
module csa_round #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0][PW-1:0] rows_in,
  input  logic [CW-1:0]            live,
  output logic [WIDTH-1:0][PW-1:0] rows_out
);

  logic [CW-1:0] ngrp;
  logic [CW-1:0] rem;

  assign ngrp = live / CW'(3);
  assign rem  = CW'(live % CW'(3));

  always_comb begin
    rows_out = '0;
    // full triples: sum into even slot, carry (one column left) into odd slot
    for (int g = 0; g < WIDTH / 3; g++) begin
      if (CW'(g) < ngrp) begin
        rows_out[2*g]   = rows_in[3*g] ^ rows_in[3*g+1] ^ rows_in[3*g+2];
        rows_out[2*g+1] = ((rows_in[3*g]   & rows_in[3*g+1]) |
                           (rows_in[3*g]   & rows_in[3*g+2]) |
                           (rows_in[3*g+1] & rows_in[3*g+2])) << 1;
      end
    end
    // first leftover: adder with zero, sum equals the row, carry is zero
    for (int g = 0; g <= (WIDTH - 1) / 3; g++) begin
      if (CW'(g) == ngrp && rem != '0) rows_out[2*g] = rows_in[3*g];
    end
    // second leftover: copied unchanged
    for (int g = 0; g <= (WIDTH - 2) / 3; g++) begin
      if (CW'(g) == ngrp && rem == CW'(2)) rows_out[2*g+1] = rows_in[3*g+1];
    end
  end

endmodule

// File: rtl/csa_final_add.sv
module csa_final_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  // carry-propagate stage; adder architecture is left to the mapping flow
  assign s = x + y;

endmodule

// File: rtl/csa_mult_iter.sv
module csa_mult_iter
  import csa_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               done_o,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int PW = 2 * WIDTH;
  localparam int NR = round_total(WIDTH);
  localparam int RW = $clog2(NR + 2);
  localparam int CW = $clog2(WIDTH + 1);

  mult_state_e st_q, st_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic [1:0]    ph_q, ph_d;
  logic          done_q;
  logic [PW-1:0] prod_q, sum_w;
  logic [WIDTH-1:0] a_q, b_q;
  logic [WIDTH-1:0][PW-1:0] rows_q, rows_d, rows_pp, rows_red;
  logic [CW-1:0] live_w;
  logic op_en, rows_en, prod_en;

  csa_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .mcand (a_q),
    .mplier(b_q),
    .rows  (rows_pp)
  );

  always_comb begin
    live_w = '0;
    for (int k = 0; k < NR; k++) begin
      if (rnd_q == RW'(k)) live_w = CW'(rows_at_round(WIDTH, k));
    end
  end

  csa_round #(.WIDTH(WIDTH)) u_round (
    .rows_in (rows_q),
    .live    (live_w),
    .rows_out(rows_red)
  );

  csa_final_add #(.W(PW)) u_add (
    .x(rows_q[0]),
    .y(rows_q[1]),
    .s(sum_w)
  );

  // enables
  assign op_en   = (st_q == ST_IDLE) && start_i;
  assign rows_en = (st_q == ST_GEN) || ((st_q == ST_RED) && (ph_q == 2'd2));
  assign rows_d  = (st_q == ST_GEN) ? rows_pp : rows_red;
  assign prod_en = (st_q == ST_ADD);

  // next state
  always_comb begin
    st_d  = st_q;
    rnd_d = rnd_q;
    ph_d  = ph_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_GEN;
      ST_GEN: begin
        rnd_d = '0;
        ph_d  = '0;
        st_d  = (NR == 0) ? ST_ADD : ST_RED;
      end
      ST_RED: begin
        if (ph_q == 2'd2) begin
          ph_d = '0;
          if (rnd_q == RW'(NR - 1)) st_d = ST_ADD;
          else rnd_d = rnd_q + 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      ST_ADD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      ph_q   <= '0;
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      st_q   <= st_d;
      rnd_q  <= rnd_d;
      ph_q   <= ph_d;
      done_q <= prod_en;
      if (prod_en) prod_q <= sum_w;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (op_en) begin
      a_q <= a_i;
      b_q <= b_i;
    end
    if (rows_en) rows_q <= rows_d;
  end

  assign done_o = done_q;
  assign prod_o = prod_q;

endmodule

// File: rtl/csa_mult_chk.sv
module csa_mult_chk
  import csa_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start,
  input logic                           done,
  input logic [2*WIDTH-1:0]             prod,
  input mult_state_e                    st,
  input logic [WIDTH-1:0]               a_q,
  input logic [WIDTH-1:0]               b_q,
  input logic [WIDTH-1:0][2*WIDTH-1:0]  rows
);

  localparam int PW  = 2 * WIDTH;
  localparam int LAT = 2 + 3 * round_total(WIDTH);

  logic [PW-1:0] row_sum;
  logic [PW-1:0] ref_prod;
  logic [15:0]   lat_q;

  always_comb begin
    row_sum = '0;
    for (int i = 0; i < WIDTH; i++) row_sum = row_sum + rows[i];
  end

  assign ref_prod = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (start && st == ST_IDLE) lat_q <= 16'd1;
    else if (lat_q != '0 && lat_q != '1) lat_q <= lat_q + 16'd1;
  end

  p_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod == ref_prod);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == 16'(LAT + 1));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));

  p_row_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RED) |-> row_sum == ref_prod);

endmodule

bind csa_mult_iter csa_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start_i),
  .done (done_o),
  .prod (prod_o),
  .st   (st_q),
  .a_q  (a_q),
  .b_q  (b_q),
  .rows (rows_q)
);

// File: tb/sim_csa_mult_iter.sv
module sim_csa_mult_iter;

  localparam int W       = 8;
  localparam int EXP_LAT = 14;   // R3: 8 rows -> 4 rounds -> 2+3*4

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] a_i, b_i;
  logic         done_o;
  logic [2*W-1:0] prod_o;

  int checks;
  int failures;

  csa_mult_iter #(.WIDTH(W)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .done_o (done_o),
    .prod_o (prod_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge while idle; returns at the falling edge after the accepting edge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    a_i = a;
    b_i = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic mul_check(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int n;
    launch(a, b);
    wait_done(n);
    chk(n == EXP_LAT, {tag, " R3 latency"}, n, EXP_LAT);
    chk(prod_o == 16'(a) * 16'(b), {tag, " R2 R7 product"}, prod_o, 16'(a) * 16'(b));
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start_i = 1'b0;
    a_i = '0;
    b_i = '0;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
    chk(prod_o == '0, "R1 product in reset", prod_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(prod_o == '0, "R1 product after reset", prod_o, 0);
  endtask

  task automatic t_exhaustive4;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        mul_check(W'(x), W'(y), "exh4");
  endtask

  task automatic t_corners;
    mul_check(8'd255, 8'd255, "max");
    mul_check(8'd0, 8'd255, "zero_a");
    mul_check(8'd255, 8'd0, "zero_b");
    mul_check(8'd128, 8'd128, "msb");
    mul_check(8'd255, 8'd1, "unit");
    mul_check(8'd170, 8'd85, "alt");
  endtask

  task automatic t_random;
    for (int i = 0; i < 150; i++)
      mul_check(W'($urandom()), W'($urandom()), "rand");
  endtask

  task automatic t_hold;
    int n;
    logic [2*W-1:0] held;
    launch(8'd201, 8'd37);
    wait_done(n);
    held = prod_o;
    chk(held == 16'd7437, "R4 product", held, 7437);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R4 done one cycle", done_o, 0);
      chk(prod_o == held, "R4 product held", prod_o, held);
    end
  endtask

  task automatic t_busy_start;
    int n;
    launch(8'd13, 8'd250);
    repeat (3) @(negedge clk);
    a_i = 8'd99;
    b_i = 8'd77;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    chk(n == EXP_LAT - 4, "R5 latency unaffected", n, EXP_LAT - 4);
    chk(prod_o == 16'd3250, "R5 first result kept", prod_o, 3250);
    for (int i = 0; i < EXP_LAT + 6; i++) begin
      @(negedge clk);
      chk(done_o == 1'b0, "R5 no extra result", done_o, 0);
    end
  endtask

  task automatic t_operand_change;
    int n;
    launch(8'd240, 8'd15);
    repeat (2) @(negedge clk);
    a_i = 8'd3;
    b_i = 8'd5;
    wait_done(n);
    chk(prod_o == 16'd3600, "R6 captured operands", prod_o, 3600);
    @(negedge clk);
  endtask

  task automatic t_back2back;
    int n;
    launch(8'd11, 8'd12);
    wait_done(n);
    chk(prod_o == 16'd132, "R8 first product", prod_o, 132);
    launch(8'd250, 8'd199);
    wait_done(n);
    chk(n == EXP_LAT, "R8 second latency", n, EXP_LAT);
    chk(prod_o == 16'd49750, "R8 second product", prod_o, 49750);
    @(negedge clk);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    @(negedge clk);
    t_reset();
    t_corners();
    t_exhaustive4();
    t_random();
    t_hold();
    t_busy_start();
    t_operand_change();
    t_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule